// File: doc/BRIEF.md
# Device Interrupt Pin Route Table

This block decides which of eight shared interrupt request lines (numbered 0 to 7, where 4 to 7 form the upper half) each device slot's four interrupt pins drive. A contiguous group of slots owns one 16-bit route word each. The words sit in a small little-endian byte window that is written and read through a simple request port. Any request may cover one to four bytes. The part of an access that runs past the window end is cut off.

A combinational lookup port takes a slot number and a pin number and returns the 3-bit line index. Slots outside the programmable group follow a fixed rotation. One slot inside the group is tied to its own fixed mapping: its word is not stored and always reads as zero. Every accepted write raises a one-cycle `route_changed` pulse on the next cycle so that listeners can re-read their routing.

The pulse comes from a two-state machine. `NS_QUIET` is the reset state. The transition `quiet_to_announce` fires on a write and enters `NS_ANNOUNCE`, where `route_changed` is high. `announce_hold` keeps it in `NS_ANNOUNCE` when another write arrives in that cycle. `announce_to_quiet` returns it to `NS_QUIET` when no write arrives.

Top module: `route_table`

## Requirements
- R1: While `rst_n` is low and after it is released, `rd_valid` and `route_changed` are 0. After reset, the word of slot s (25 to 31, not 30) holds, in the field of pin n, the value ((s+n) mod 4)+4. The word of slot 30 is zero.
- R2: The word of slot 25+k occupies byte offsets 2k (bits 7:0) and 2k+1 (bits 15:8). A read of size code z returns the bytes at addr..addr+z. The byte at addr is in `rd_data[7:0]` and the following bytes are in successive higher lanes. Unused lanes read 0.
- R3: A write of size code z replaces only the bytes at addr..addr+z, taking lane b of `bus_wdata` for byte addr+b. Every other byte keeps its value.
- R4: The window holds 14 bytes (offsets 0 to 13). On a write, lanes whose offset is 14 or more are dropped. On a read, those lanes return 0. An access that starts at offset 14 or 15 writes nothing and reads all zeros.
- R5: Writes to offsets 10 and 11 (slot 30) are ignored, and those bytes always read 0. The lookup of slot 30 pin n returns 4+n.
- R6: For slots 25 to 31 except 30, the field of pin n is bits 4n+3 to 4n of the slot's word. The lookup returns that field's low 3 bits. Bit 4n+3 is stored and read back, but it does not affect the lookup.
- R7: For slots 0 to 24, the lookup returns ((slot+pin) mod 4)+4, whatever has been written.
- R8: `route_changed` is high in exactly the cycles that follow a cycle with an accepted write (`bus_valid` and `bus_write` both 1). This includes writes that are clipped to nothing. It is low after reads and idle cycles.
- R9: A read accepted in one cycle gives `rd_valid` high for one cycle with its data in the next cycle. No read in a cycle means `rd_valid` is low in the next cycle.
- R10: The lookup is combinational. It reflects a write from the cycle after that write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the first byte in the window |
| bus_size | input | 2 | Byte count minus one (0 to 3) |
| bus_wdata | input | 32 | Write bytes; lane b goes to offset addr+b |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read bytes, offset addr in bits 7:0 |
| lk_slot | input | 5 | Slot number to look up |
| lk_pin | input | 2 | Pin number, 0 = first pin |
| lk_pirq | output | 3 | Interrupt request line index for that slot and pin |
| route_changed | output | 1 | One-cycle pulse after each accepted write |

## Verification
The bench builds the block with its default parameters: seven programmable slots starting at slot 25, with slot 30 fixed, four 4-bit fields per word, 3-bit line indices and a 4-bit window address. With those values the window has only 14 bytes inside a 16-byte address range. This lets every offset be reached, and it makes both the clipped tail (starts at 12 and 13) and the fully outside starts (14 and 15) reachable with single requests. All 128 slot and pin combinations are swept, covering the rotation region, the fixed slot and every programmable field, including field values with the ignored top bit set.

// File: rtl/route_tbl_pkg.sv
package route_tbl_pkg;

    // Byte lanes carried by one request beat.
    localparam int BUS_LANES = 4;
    localparam int BUS_W     = 8 * BUS_LANES;
    localparam int SIZE_W    = $clog2(BUS_LANES);

    typedef enum logic {
        NS_QUIET    = 1'b0,
        NS_ANNOUNCE = 1'b1
    } notify_state_e;

endpackage

// File: rtl/route_notify_fsm.sv
module route_notify_fsm
    import route_tbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    output logic route_changed
);

    notify_state_e state_q;
    notify_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NS_QUIET:    if (wr_fire)  state_d = NS_ANNOUNCE;  // quiet_to_announce
            NS_ANNOUNCE: if (!wr_fire) state_d = NS_QUIET;     // announce_to_quiet
            default:     state_d = NS_QUIET;
        endcase
    end

    always_comb begin
        route_changed = (state_q == NS_ANNOUNCE);
    end

    p_notify_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> route_changed);

    p_notify_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> !route_changed);

endmodule

// File: rtl/route_store.sv
module route_store
    import route_tbl_pkg::*;
#(
    parameter int FIRST_SLOT = 25,
    parameter int NUM_BANK   = 7,
    parameter int FIXED_SLOT = 30,
    parameter int PIN_CNT    = 4,
    parameter int FIELD_W    = 4,
    parameter int NUM_PIRQ   = 8,
    parameter int ADDR_W     = 4,
    parameter int BANK_W     = NUM_BANK * PIN_CNT * FIELD_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [BUS_W-1:0]  wdata,
    output logic              rd_valid,
    output logic [BUS_W-1:0]  rd_data,
    output logic [BANK_W-1:0] bank_bits
);

    localparam int REG_W     = PIN_CNT * FIELD_W;
    localparam int REG_BYTES = REG_W / 8;
    localparam int WIN_BYTES = NUM_BANK * REG_BYTES;
    localparam int AW1       = ADDR_W + 1;
    localparam int HALF      = NUM_PIRQ / 2;
    localparam int FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

    // Reset contents: the rotation mapping, packed per pin.
    function automatic logic [7:0] reset_byte(int idx);
        int               slot;
        logic [REG_W-1:0] word;
        slot = FIRST_SLOT + idx / REG_BYTES;
        word = '0;
        for (int n = 0; n < PIN_CNT; n++) begin
            word[n*FIELD_W +: FIELD_W] = FIELD_W'(HALF + (slot + n) % HALF);
        end
        return 8'(word >> (8 * (idx % REG_BYTES)));
    endfunction

    logic [AW1-1:0] addr_x;
    assign addr_x = {1'b0, addr};

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
        localparam logic [AW1-1:0] POS = AW1'(i);
        if (i / REG_BYTES == FIXED_IDX) begin : g_fixed
            assign bank_bits[8*i +: 8] = 8'h00;
        end else begin : g_live
            logic [7:0]        byte_q;
            logic [AW1-1:0]    rel;
            logic [SIZE_W-1:0] lane;
            logic              hit;

            always_comb begin
                rel  = POS - addr_x;
                lane = rel[SIZE_W-1:0];
                hit  = wr_en && (POS >= addr_x) && (rel <= AW1'(size));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    byte_q <= reset_byte(i);
                end else if (hit) begin
                    byte_q <= wdata[{lane, 3'b000} +: 8];
                end
            end

            assign bank_bits[8*i +: 8] = byte_q;
        end
    end

    logic [BUS_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < BUS_LANES; b++) begin
            for (int i = 0; i < WIN_BYTES; i++) begin
                if ((AW1'(b) <= AW1'(size)) && ((addr_x + AW1'(b)) == AW1'(i))) begin
                    rd_next[8*b +: 8] = bank_bits[8*i +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_next;
            end
        end
    end

    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_bits));

endmodule

// File: rtl/route_lookup.sv
module route_lookup #(
    parameter int FIRST_SLOT = 25,
    parameter int NUM_BANK   = 7,
    parameter int FIXED_SLOT = 30,
    parameter int PIN_CNT    = 4,
    parameter int FIELD_W    = 4,
    parameter int PIRQ_W     = 3,
    parameter int SLOT_W     = 5,
    parameter int PIN_W      = 2,
    parameter int BANK_W     = NUM_BANK * PIN_CNT * FIELD_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_bits,
    input  logic [SLOT_W-1:0] lk_slot,
    input  logic [PIN_W-1:0]  lk_pin,
    output logic [PIRQ_W-1:0] lk_pirq
);

    localparam int REG_W     = PIN_CNT * FIELD_W;
    localparam int HALF      = 2 ** (PIRQ_W - 1);
    localparam int FIXED_IDX = FIXED_SLOT - FIRST_SLOT;

    logic [SLOT_W:0] sum;

    always_comb begin
        sum     = (SLOT_W+1)'(lk_slot) + (SLOT_W+1)'(lk_pin);
        lk_pirq = {1'b1, sum[PIRQ_W-2:0]};
        if (lk_slot == SLOT_W'(FIXED_SLOT)) begin
            lk_pirq = PIRQ_W'(HALF) + PIRQ_W'(lk_pin);
        end else begin
            for (int k = 0; k < NUM_BANK; k++) begin
                if (k != FIXED_IDX && lk_slot == SLOT_W'(FIRST_SLOT + k)) begin
                    for (int n = 0; n < PIN_CNT; n++) begin
                        if (lk_pin == PIN_W'(n)) begin
                            lk_pirq = bank_bits[k*REG_W + n*FIELD_W +: PIRQ_W];
                        end
                    end
                end
            end
        end
    end

    p_low_slots_upper_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot < SLOT_W'(FIRST_SLOT)) |-> lk_pirq[PIRQ_W-1]);

endmodule

// File: rtl/route_table.sv
module route_table
    import route_tbl_pkg::*;
#(
    parameter int FIRST_SLOT = 25,
    parameter int NUM_BANK   = 7,
    parameter int FIXED_SLOT = 30,
    parameter int PIN_CNT    = 4,
    parameter int FIELD_W    = 4,
    parameter int PIRQ_W     = 3,
    parameter int SLOT_W     = 5,
    parameter int ADDR_W     = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [SIZE_W-1:0]          bus_size,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic                       rd_valid,
    output logic [BUS_W-1:0]           rd_data,
    input  logic [SLOT_W-1:0]          lk_slot,
    input  logic [$clog2(PIN_CNT)-1:0] lk_pin,
    output logic [PIRQ_W-1:0]          lk_pirq,
    output logic                       route_changed
);

    localparam int PIN_W     = $clog2(PIN_CNT);
    localparam int REG_W     = PIN_CNT * FIELD_W;
    localparam int BANK_W    = NUM_BANK * REG_W;
    localparam int WIN_BYTES = BANK_W / 8;
    localparam int NUM_PIRQ  = 2 ** PIRQ_W;

    logic              wr_fire;
    logic              rd_fire;
    logic [BANK_W-1:0] bank_bits;

    assign wr_fire = bus_valid && bus_write;
    assign rd_fire = bus_valid && !bus_write;

    route_store #(
        .FIRST_SLOT (FIRST_SLOT),
        .NUM_BANK   (NUM_BANK),
        .FIXED_SLOT (FIXED_SLOT),
        .PIN_CNT    (PIN_CNT),
        .FIELD_W    (FIELD_W),
        .NUM_PIRQ   (NUM_PIRQ),
        .ADDR_W     (ADDR_W),
        .BANK_W     (BANK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_fire),
        .rd_en     (rd_fire),
        .addr      (bus_addr),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .bank_bits (bank_bits)
    );

    route_lookup #(
        .FIRST_SLOT (FIRST_SLOT),
        .NUM_BANK   (NUM_BANK),
        .FIXED_SLOT (FIXED_SLOT),
        .PIN_CNT    (PIN_CNT),
        .FIELD_W    (FIELD_W),
        .PIRQ_W     (PIRQ_W),
        .SLOT_W     (SLOT_W),
        .PIN_W      (PIN_W),
        .BANK_W     (BANK_W)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_bits (bank_bits),
        .lk_slot   (lk_slot),
        .lk_pin    (lk_pin),
        .lk_pirq   (lk_pirq)
    );

    route_notify_fsm u_notify (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_fire       (wr_fire),
        .route_changed (route_changed)
    );

    p_rd_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rd_valid);

    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !rd_valid);

    p_clip_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && (bus_addr >= ADDR_W'(WIN_BYTES))) |=> (rd_data == '0));

endmodule

// File: tb/tb_route_table.sv
module tb_route_table;

    localparam int WB = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;
    logic        route_changed;

    always #10 clk = ~clk;

    route_table dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .bus_write     (bus_write),
        .bus_addr      (bus_addr),
        .bus_size      (bus_size),
        .bus_wdata     (bus_wdata),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .lk_slot       (lk_slot),
        .lk_pin        (lk_pin),
        .lk_pirq       (lk_pirq),
        .route_changed (route_changed)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int mem [WB];
    int exp_rdv = 0;
    int exp_ntf = 0;
    int exp_rd  = 0;
    int prev_wr = 0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int def_byte(int i);
        int slot = 25 + i / 2;
        int w = 0;
        if (i / 2 == 5) return 0;
        for (int n = 0; n < 4; n++) w |= (((slot + n) % 4) + 4) << (4 * n);
        return (w >> (8 * (i % 2))) & 255;
    endfunction

    function automatic int ref_pirq(int slot, int pin);
        int w;
        if (slot < 25) return ((slot + pin) % 4) + 4;
        if (slot == 30) return 4 + pin;
        w = mem[2*(slot-25)] | (mem[2*(slot-25)+1] << 8);
        return (w >> (4 * pin)) & 7;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WB; i++) mem[i] = def_byte(i);
        exp_rdv = 0;
        exp_ntf = 0;
        prev_wr = 0;
    endtask

    // One bus cycle: drive at negedge, check lookup, update model at posedge,
    // compare registered outputs at the following negedge.
    task automatic cyc(int v, int w, int a, int s, int d, int sl, int pn, string rtag);
        string ltag;
        bus_valid = v[0];
        bus_write = w[0];
        bus_addr  = 4'(a);
        bus_size  = 2'(s);
        bus_wdata = 32'(d);
        lk_slot   = 5'(sl);
        lk_pin    = 2'(pn);
        #1;
        if (prev_wr != 0)   ltag = "R10 lookup after write";
        else if (sl < 25)   ltag = "R7 rotation lookup";
        else if (sl == 30)  ltag = "R5 fixed slot lookup";
        else                ltag = "R6 field lookup";
        chk(ltag, int'(lk_pirq), ref_pirq(sl, pn));
        @(posedge clk);
        exp_ntf = (v != 0 && w != 0) ? 1 : 0;
        exp_rdv = (v != 0 && w == 0) ? 1 : 0;
        prev_wr = exp_ntf;
        if (exp_rdv != 0) begin
            exp_rd = 0;
            for (int b = 0; b <= s; b++)
                if (a + b < WB) exp_rd |= mem[a+b] << (8 * b);
        end
        if (exp_ntf != 0) begin
            for (int b = 0; b <= s; b++)
                if (a + b < WB && a + b != 10 && a + b != 11)
                    mem[a+b] = (d >> (8 * b)) & 255;
        end
        @(negedge clk);
        chk("R9 rd_valid", int'(rd_valid), exp_rdv);
        chk("R8 route_changed", int'(route_changed), exp_ntf);
        if (exp_rdv != 0) chk(rtag, int'(rd_data), exp_rd);
    endtask

    task automatic idle(int sl, int pn);
        cyc(0, 0, 0, 0, 0, sl, pn, "R2");
    endtask

    task automatic rd(int a, int s, string tag);
        cyc(1, 0, a, s, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, int s, int d);
        cyc(1, 1, a, s, d, 25, 0, "R3");
    endtask

    task automatic sweep();
        for (int sl = 0; sl < 32; sl++)
            for (int pn = 0; pn < 4; pn++) idle(sl, pn);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_valid = 1'b0;
        model_reset();
        repeat (3) begin
            @(negedge clk);
            chk("R1 rd_valid in reset", int'(rd_valid), 0);
            chk("R1 route_changed in reset", int'(route_changed), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        idle(0, 0);
        // R1: reset contents of every word
        for (int k = 0; k < 7; k++) rd(2 * k, 1, (k == 5) ? "R5 fixed word reads zero" : "R1 reset word");
        sweep();

        // R3: single byte write leaves neighbours alone
        wr(0, 0, 32'h000000A9);
        rd(0, 3, "R3 byte write isolation");
        // R6: top bit of a field is stored but ignored by lookup
        wr(3, 0, 32'h000000F2);
        idle(26, 2);
        idle(26, 3);
        rd(2, 1, "R6 field readback with top bit");
        // R4: tail clipping on write and read
        wr(12, 3, 32'h44332211);
        rd(12, 3, "R4 clipped read");
        rd(13, 3, "R4 clipped read last byte");
        wr(15, 3, 32'hDEADBEEF);
        rd(14, 1, "R4 read outside window");
        rd(15, 3, "R4 read outside window");
        // R5: fixed slot ignores writes
        wr(10, 1, 32'h0000FFFF);
        rd(10, 1, "R5 fixed word after write");
        idle(30, 0);
        idle(30, 3);
        wr(8, 3, 32'h89ABCDEF);
        rd(8, 3, "R5 write spanning fixed word");
        // R8: back-to-back writes then a read
        wr(4, 1, 32'h00007654);
        wr(6, 1, 32'h00000123);
        wr(6, 0, 32'h000000FF);
        rd(4, 3, "R2 multi-byte little endian");
        idle(27, 1);
        // R7: low slots unaffected after writes
        for (int sl = 0; sl < 25; sl++) idle(sl, sl % 4);

        for (int t = 0; t < 400; t++) begin
            int v = ($urandom % 4 != 0) ? 1 : 0;
            cyc(v, int'($urandom % 2), int'($urandom % 16), int'($urandom % 4),
                int'($urandom), int'($urandom % 32), int'($urandom % 4), "R2 random read");
        end
        sweep();

        // R1: second reset restores defaults
        do_reset();
        idle(0, 0);
        for (int k = 0; k < 7; k++) rd(2 * k, 1, "R1 word after second reset");
        idle(25, 0);
        finish_run();
    end

endmodule